// File: doc/BRIEF.md
# Event Aggregation and Pending Monitor

This block watches a group of event lines and records each detected event in a sticky pending bit. It then combines those bits into one request line for an upstream interrupt or event consumer. A separate enable bit per event decides whether a recorded event reaches that line. Pending bits are captured whether or not their enable is set. Software sets the enables and acknowledges events through a small register port. The port has an address, a read strobe, a write strobe, write data and registered read data.

A build-time parameter selects one detection rule for all event lines. Level mode takes the line itself as the trigger. Rising mode takes the 0-to-1 transition, and falling mode takes the 1-to-0 transition. The edge modes compare each line with a registered copy of its previous value. Writing a one to a pending bit acknowledges that event. If a new trigger arrives in the same cycle as the acknowledge, the trigger takes priority, so an event that is still active is recorded again.

The register port is plain control access with no handshake. A strobe is accepted in the cycle it is high, and the port never stalls.

Top module: `evt_pend_mon`

## Requirements
- R1: Parameter TRIG_SEL selects the trigger rule: 0 is level, 1 is rising edge and 2 is falling edge. Any other value is rejected at elaboration.
- R2: After reset the enable and pending registers are 0, `irq_o` is low and `csr_rdata_o` is 0.
- R3: Address 0 holds the enable register, with event k at bit k. A write loads write-data bits N-1:0 at the next clock edge. A read returns the enable bits, and data bits above N-1 read as zero.
- R4: Address 1 holds the pending register, with event k at bit k. A write clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: In level mode, a pending bit is set at every clock edge where its event input is 1.
- R6: In rising mode, a pending bit is set only at the edge that follows a 0-to-1 change of its input. An input that stays high does not set the bit again.
- R7: In falling mode, a pending bit is set only at the edge that follows a 1-to-0 change of its input.
- R8: A set pending bit stays set after its input returns to idle, until software clears it.
- R9: When a trigger and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: Pending bits capture triggers whether or not the event is enabled. `irq_o` is high exactly when some bit is both enabled and pending, and it follows the registers with no added delay.
- R11: Read data is registered. It updates at the clock edge where `csr_rd_i` is high and holds until the next read. Addresses other than 0 and 1 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Subordinate event lines |
| csr_addr_i | input | AW | Register address |
| csr_rd_i | input | 1 | Read strobe |
| csr_wr_i | input | 1 | Write strobe |
| csr_wdata_i | input | DW | Write data |
| csr_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Aggregated request: any event enabled and pending |

## Verification
The assertions assume that the event lines and the strobes are synchronous to `clk`. They also assume that the address and write data are stable during the cycle in which a strobe is sampled. Read and write are never expected in the same cycle. The bench drives every input on the falling clock edge and raises one strobe per access. It shares one set of event patterns among three instances, one per trigger rule. This lets a single pattern expose the differences between level, rising and falling capture, including a clear issued while an event line is still high.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  localparam int TRIG_LEVEL = 0;
  localparam int TRIG_RISE  = 1;
  localparam int TRIG_FALL  = 2;

  localparam int ADDR_ENABLE  = 0;
  localparam int ADDR_PENDING = 1;

  typedef enum logic [1:0] {
    REG_ENABLE  = 2'd0,
    REG_PENDING = 2'd1,
    REG_NONE    = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/evt_trig_detect.sv
module evt_trig_detect #(
  parameter int N        = 4,
  parameter int TRIG_SEL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] trig_o
);
  import evt_mon_pkg::*;

  if (TRIG_SEL == TRIG_LEVEL) begin : g_level
    logic [N-1:0] unused_clk_rst;
    assign unused_clk_rst = {N{clk ^ rst_n}};
    assign trig_o = evt_i;
  end else begin : g_edge
    logic [N-1:0] prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= evt_i;
    end
    for (genvar k = 0; k < N; k++) begin : g_bit
      if (TRIG_SEL == TRIG_RISE) begin : g_rise
        assign trig_o[k] = evt_i[k] & ~prev_q[k];
      end else begin : g_fall
        assign trig_o[k] = ~evt_i[k] & prev_q[k];
      end
    end
  end
endmodule

// File: rtl/evt_pend_regs.sv
module evt_pend_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] pending_o,
  output logic         irq_o
);
  logic [N-1:0] enable_q;
  logic [N-1:0] pending_q;

  // Trigger is OR-ed after the clear mask, so a same-cycle trigger wins (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= '0;
      pending_q <= '0;
    end else begin
      if (en_wr_i) enable_q <= en_wdata_i;
      pending_q <= (pending_q & ~clr_i) | trig_i;
    end
  end

  assign enable_o  = enable_q;
  assign pending_o = pending_q;
  assign irq_o     = |(enable_q & pending_q);
endmodule

// File: rtl/evt_csr_port.sv
module evt_csr_port #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  enable_i,
  input  logic [N-1:0]  pending_i,
  output logic          en_wr_o,
  output logic [N-1:0]  en_wdata_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata_o
);
  import evt_mon_pkg::*;

  localparam int PAD = DW - N;

  reg_sel_e     sel;
  logic [DW-1:0] rdata_q;

  always_comb begin
    if (addr_i == AW'(ADDR_ENABLE))       sel = REG_ENABLE;
    else if (addr_i == AW'(ADDR_PENDING)) sel = REG_PENDING;
    else                                  sel = REG_NONE;
  end

  assign en_wr_o    = wr_i && (sel == REG_ENABLE);
  assign en_wdata_o = wdata_i[N-1:0];
  assign clr_o      = (wr_i && (sel == REG_PENDING)) ? wdata_i[N-1:0] : '0;

  if (PAD > 0) begin : g_pad
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DW-1:N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      case (sel)
        REG_ENABLE:  rdata_q <= DW'(enable_i);
        REG_PENDING: rdata_q <= DW'(pending_i);
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/evt_pend_mon.sv
module evt_pend_mon #(
  parameter int N        = 4,
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int TRIG_SEL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic [AW-1:0] csr_addr_i,
  input  logic          csr_rd_i,
  input  logic          csr_wr_i,
  input  logic [DW-1:0] csr_wdata_i,
  output logic [DW-1:0] csr_rdata_o,
  output logic          irq_o
);
  // R1: only three trigger rules exist
  if (TRIG_SEL < 0 || TRIG_SEL > 2) begin : g_bad_trig
    $error("evt_pend_mon: TRIG_SEL must be 0, 1 or 2");
  end
  if (DW < N) begin : g_bad_width
    $error("evt_pend_mon: DW must be at least N");
  end

  logic [N-1:0] trig_w;
  logic [N-1:0] enable_w;
  logic [N-1:0] pending_w;
  logic [N-1:0] clr_w;
  logic [N-1:0] en_wdata_w;
  logic         en_wr_w;

  evt_trig_detect #(.N(N), .TRIG_SEL(TRIG_SEL)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .trig_o (trig_w)
  );

  evt_pend_regs #(.N(N)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_w),
    .en_wr_i    (en_wr_w),
    .en_wdata_i (en_wdata_w),
    .clr_i      (clr_w),
    .enable_o   (enable_w),
    .pending_o  (pending_w),
    .irq_o      (irq_o)
  );

  evt_csr_port #(.N(N), .DW(DW), .AW(AW)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (csr_addr_i),
    .rd_i       (csr_rd_i),
    .wr_i       (csr_wr_i),
    .wdata_i    (csr_wdata_i),
    .enable_i   (enable_w),
    .pending_i  (pending_w),
    .en_wr_o    (en_wr_w),
    .en_wdata_o (en_wdata_w),
    .clr_o      (clr_w),
    .rdata_o    (csr_rdata_o)
  );
endmodule

// File: rtl/evt_pend_mon_chk.sv
module evt_pend_mon_chk #(
  parameter int N        = 4,
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int TRIG_SEL = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_i,
  input logic [AW-1:0] csr_addr_i,
  input logic          csr_rd_i,
  input logic          csr_wr_i,
  input logic [DW-1:0] csr_wdata_i,
  input logic [DW-1:0] csr_rdata_o,
  input logic          irq_o,
  input logic [N-1:0]  trig_w,
  input logic [N-1:0]  enable_w,
  input logic [N-1:0]  pending_w
);
  logic [N-1:0] prev_c;
  logic [N-1:0] exp_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_c <= '0;
    else        prev_c <= evt_i;
  end

  if (TRIG_SEL == 0) begin : g_lvl
    assign exp_trig = evt_i;
    a_r5_level_trig: assert property (@(posedge clk) disable iff (!rst_n)
      trig_w == exp_trig);
  end else if (TRIG_SEL == 1) begin : g_rise
    assign exp_trig = evt_i & ~prev_c;
    a_r6_rise_trig: assert property (@(posedge clk) disable iff (!rst_n)
      trig_w == exp_trig);
  end else begin : g_fall
    assign exp_trig = ~evt_i & prev_c;
    a_r7_fall_trig: assert property (@(posedge clk) disable iff (!rst_n)
      trig_w == exp_trig);
  end

  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_i && csr_addr_i == AW'(0)) |=> enable_w == $past(csr_wdata_i[N-1:0]));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_i && csr_addr_i == AW'(1)) |=>
      (pending_w & $past(csr_wdata_i[N-1:0] & ~trig_w)) == '0);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr_i && csr_addr_i == AW'(1)) |=> (pending_w & $past(pending_w)) == $past(pending_w));

  a_r9_trig_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_w != '0) |=> (pending_w & $past(trig_w)) == $past(trig_w));

  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_w == '0) |-> !irq_o);

  a_r11_read_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_i && csr_addr_i == AW'(0)) |=> csr_rdata_o == DW'($past(enable_w)));

  a_r11_bad_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_i && csr_addr_i > AW'(1)) |=> $stable(enable_w));

  a_r11_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd_i |=> $stable(csr_rdata_o));
endmodule

bind evt_pend_mon evt_pend_mon_chk #(.N(N), .DW(DW), .AW(AW), .TRIG_SEL(TRIG_SEL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .csr_addr_i  (csr_addr_i),
  .csr_rd_i    (csr_rd_i),
  .csr_wr_i    (csr_wr_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .irq_o       (irq_o),
  .trig_w      (trig_w),
  .enable_w    (enable_w),
  .pending_w   (pending_w)
);

// File: tb/test_evt_pend_mon.sv
module test_evt_pend_mon;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_l, rdata_r, rdata_f;
  logic          irq_l, irq_r, irq_f;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] vl, vr, vf;

  always #10 clk = ~clk;

  evt_pend_mon #(.N(N), .DW(DW), .AW(AW), .TRIG_SEL(0)) i_evt_pend_mon (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .csr_addr_i(addr), .csr_rd_i(rd),
    .csr_wr_i(wr), .csr_wdata_i(wdata), .csr_rdata_o(rdata_l), .irq_o(irq_l));
  evt_pend_mon #(.N(N), .DW(DW), .AW(AW), .TRIG_SEL(1)) i_evt_pend_mon_rise (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .csr_addr_i(addr), .csr_rd_i(rd),
    .csr_wr_i(wr), .csr_wdata_i(wdata), .csr_rdata_o(rdata_r), .irq_o(irq_r));
  evt_pend_mon #(.N(N), .DW(DW), .AW(AW), .TRIG_SEL(2)) i_evt_pend_mon_fall (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .csr_addr_i(addr), .csr_rd_i(rd),
    .csr_wr_i(wr), .csr_wdata_i(wdata), .csr_rdata_o(rdata_f), .irq_o(irq_f));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    vl = rdata_l; vr = rdata_r; vf = rdata_f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 irq level", irq_l, 0);
    chk("R2 rdata", rdata_l, 0);
    bus_read(0);
    chk("R2 enable zero", vl, 0);
    bus_read(1);
    chk("R2 pending zero", vl | vr | vf, 0);
  endtask

  task automatic t_capture_masked;
    evt = 4'b0001;
    idle(2);
    chk("R10 irq masked while enable zero", {irq_l, irq_r, irq_f}, 3'b000);
    bus_read(1);
    chk("R5 level pending", vl, 8'h01);
    chk("R6 rise pending", vr, 8'h01);
    chk("R7 fall no capture on rise", vf, 8'h00);
  endtask

  task automatic t_enable;
    bus_write(0, 8'hFF);
    bus_read(0);
    chk("R3 enable readback zero-extended", vl, 8'h0F);
    chk("R10 irq enabled+pending", {irq_l, irq_r, irq_f}, 3'b110);
  endtask

  task automatic t_clear_while_high;
    bus_write(1, 8'h01);
    bus_read(1);
    chk("R9 level retriggers over clear", vl, 8'h01);
    chk("R6 rise stays cleared while high", vr, 8'h00);
    chk("R10 irq rise dropped", irq_r, 0);
  endtask

  task automatic t_fall_and_sticky;
    evt = 4'b0000;
    idle(2);
    bus_read(1);
    chk("R7 fall pending", vf, 8'h01);
    chk("R8 level sticky after input low", vl, 8'h01);
    bus_write(1, 8'h02);
    bus_read(1);
    chk("R4 zero bits unchanged", vl, 8'h01);
    bus_write(1, 8'h01);
    bus_read(1);
    chk("R4 one bits cleared", {vl, vr, vf}, 24'h0);
  endtask

  task automatic t_multi_pulse;
    @(negedge clk); evt = 4'b1010;
    @(negedge clk); evt = 4'b0000;
    idle(1);
    bus_read(1);
    chk("R5 level multi-bit", vl, 8'h0A);
    chk("R6 rise multi-bit", vr, 8'h0A);
    chk("R8 fall multi-bit sticky", vf, 8'h0A);
    bus_write(1, 8'h08);
    bus_read(1);
    chk("R4 partial clear", {vl, vr, vf}, {8'h02, 8'h02, 8'h02});
  endtask

  task automatic t_bad_addr;
    bus_write(2, 8'h00);
    bus_read(0);
    chk("R11 out-of-range write ignored", vl, 8'h0F);
    bus_read(3);
    chk("R11 out-of-range reads zero", vl, 8'h00);
    bus_read(0);
    idle(2);
    chk("R11 rdata holds without strobe", rdata_l, 8'h0F);
  endtask

  task automatic t_mask;
    bus_write(0, 8'h00);
    chk("R10 irq off with enable cleared", {irq_l, irq_r, irq_f}, 3'b000);
    bus_write(0, 8'h02);
    chk("R10 irq on for enabled pending bit", {irq_l, irq_r, irq_f}, 3'b111);
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_capture_masked();
    t_enable();
    t_clear_while_high();
    t_fall_and_sticky();
    t_multi_pulse();
    t_bad_addr();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule